// File: doc/BRIEF.md
# EDO Dynamic Memory Device Emulator

This block stands in for a multiplexed-address dynamic memory with extended data output. It is the slave end of a strobe interface: a row strobe, a column strobe, a write enable and an output enable, all active low, with one 11-bit address bus that carries the row in one phase and the column in the next. The 4-bit bidirectional data pins are split into an input word, an output word and an output-enable flag. A memory controller under development can be run against this emulator on a board or in a fast simulation.

Every strobe is sampled on the system clock, and edges are detected between successive samples. A row strobe fall with the column strobe high opens a row from the address pins. Each column strobe fall inside that row then reads or writes one word, and reads and writes may be mixed freely. Read data is not dropped when the column strobe rises. It stays on the pins until the next column strobe fall. The three refresh forms are told apart by strobe order. Each one is reported by a one-cycle pulse, together with a held kind code and the row that was refreshed. The storage array is scaled down, and address bits above its size are ignored.

Top module: `edo_dram_emu`

## Requirements
- R1: After reset, dqOe is 0, refKind is 0 (none), and the internal refresh counter starts at row 0.
- R2: The row is taken from addr on a row strobe fall when the column strobe is high. The column is taken on each later column strobe fall. If weN is low at that column fall, dqIn is stored at (row, column).
- R3: A column strobe fall with weN high inside an open row loads the addressed word onto dqOut. dqOe is 1 while oeN is low.
- R4: Read data stays on dqOut, with dqOe still 1, after the column strobe rises. It changes only at the next column strobe fall.
- R5: dqOe is 0 whenever oeN is high, after a column fall with weN low (early write), and once both strobes are high.
- R6: Any mix of reads and writes to different columns can follow one row opening within the same row strobe low period. Each access sees all earlier writes.
- R7: A column strobe fall while the row strobe is high, followed by a row strobe fall, is a counter refresh. refKind becomes 1 and refRow becomes the counter value, the array is left unchanged, and the counter then advances by one, wrapping from 2047 to 0.
- R8: A row strobe fall with the column strobe high reports refKind 2, with refRow equal to the address on the pins.
- R9: While read data is held, the row strobe going high and then low again with the column strobe kept low is a hidden refresh. refKind becomes 3 and refRow is the counter value, which then advances. The read word stays driven on dqOut throughout.
- R10: Only the low row-index and column-index bits of addr select a word, so addresses that differ only in higher bits reach the same word.
- R11: refPulse is high for exactly one cycle for each row strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low, sampled at the column fall |
| oeN | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| dqIn | input | 4 | Write data from the pins |
| dqOut | output | 4 | Read data toward the pins |
| dqOe | output | 1 | Drive enable for dqOut |
| refPulse | output | 1 | One-cycle pulse per row strobe fall |
| refKind | output | 2 | Kind of the last refresh: 0 none, 1 counter, 2 row-address, 3 hidden |
| refRow | output | 11 | Row refreshed by the last refresh |

## Verification
The hardest state to reach is the hidden refresh. It needs a read to have loaded held data, the row strobe to rise while the column strobe stays low, and the row strobe to fall again before the column strobe is ever released. Random page traffic never produces this order on its own. Directed sequences therefore open a row, read a known word, toggle only the row strobe, and check that the word is still driven while the refresh kind and the counter row are reported. Counter wrap-around is reached by a directed run of 2048 counter refreshes, and the row then reported is checked to be 0.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {
    REF_NONE   = 2'd0,
    REF_CBR    = 2'd1,
    REF_ROW    = 2'd2,
    REF_HIDDEN = 2'd3
  } ref_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rowAct;   // open a row from the address pins
    logic refInt;   // refresh from the internal counter
    logic hidden;   // refInt while read data is held
    logic rdEn;     // column read
    logic wrEn;     // column write
    logic clrHold;  // release held read data
  } ctrl_t;
endpackage

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int AW = 11,
  parameter int REF_BITS = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rasN,
  input  logic          casN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addr,
  input  logic          holdActive,
  output ctrl_t         ctl,
  output logic [AW-1:0] sAddr,
  output logic          sOe,
  output logic          refPulse,
  output logic [1:0]    refKind,
  output logic [AW-1:0] refRow
);
  logic sRas, sCas, sWe, pRas, pCas;
  logic rowOpen;
  logic [REF_BITS-1:0] refCnt;
  logic rasFall, rasRise, casFall, access;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sRas <= 1'b1; sCas <= 1'b1; sWe <= 1'b1; sOe <= 1'b1;
      pRas <= 1'b1; pCas <= 1'b1; sAddr <= '0;
    end else begin
      sRas <= rasN; sCas <= casN; sWe <= weN; sOe <= oeN;
      pRas <= sRas; pCas <= sCas; sAddr <= addr;
    end
  end

  always_comb begin
    rasFall = pRas & ~sRas;
    rasRise = ~pRas & sRas;
    casFall = pCas & ~sCas;
    access  = casFall & ~sRas & rowOpen;
    ctl.rowAct  = rasFall & sCas;
    ctl.refInt  = rasFall & ~sCas;
    ctl.hidden  = rasFall & ~sCas & holdActive;
    ctl.rdEn    = access & sWe;
    ctl.wrEn    = access & ~sWe;
    ctl.clrHold = (sRas & sCas) | (casFall & sRas);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOpen  <= 1'b0;
      refCnt   <= '0;
      refPulse <= 1'b0;
      refKind  <= REF_NONE;
      refRow   <= '0;
    end else begin
      if (ctl.rowAct) rowOpen <= 1'b1;
      else if (rasRise) rowOpen <= 1'b0;
      refPulse <= ctl.rowAct | ctl.refInt;
      if (ctl.rowAct) begin
        refKind <= REF_ROW;
        refRow  <= sAddr;
      end else if (ctl.refInt) begin
        refKind <= ctl.hidden ? REF_HIDDEN : REF_CBR;
        refRow  <= AW'(refCnt);
        refCnt  <= refCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edo_datapath.sv
module edo_datapath
  import edo_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 4,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctl,
  input  logic [AW-1:0] sAddr,
  input  logic          sOe,
  input  logic [DW-1:0] dqIn,
  output logic [DW-1:0] dqOut,
  output logic          dqOe,
  output logic          holdActive
);
  localparam int IDX_BITS = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_BITS;

  logic [DW-1:0] memArr [DEPTH];
  logic [ROW_BITS-1:0] rowReg;
  logic [DW-1:0] sDin;
  logic [IDX_BITS-1:0] idx;

  assign idx = {rowReg, sAddr[COL_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      sDin <= '0;
    end else begin
      sDin <= dqIn;
      if (ctl.rowAct) rowReg <= sAddr[ROW_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) memArr[idx] <= sDin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqOut <= '0;
      holdActive <= 1'b0;
    end else if (ctl.rdEn) begin
      dqOut <= memArr[idx];
      holdActive <= 1'b1;
    end else if (ctl.wrEn || ctl.clrHold) begin
      holdActive <= 1'b0;
    end
  end

  assign dqOe = holdActive & ~sOe;
endmodule

// File: rtl/edo_dram_emu.sv
module edo_dram_emu
  import edo_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 4,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int REF_BITS = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rasN,
  input  logic          casN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dqIn,
  output logic [DW-1:0] dqOut,
  output logic          dqOe,
  output logic          refPulse,
  output logic [1:0]    refKind,
  output logic [AW-1:0] refRow
);
  ctrl_t ctl;
  logic [AW-1:0] sAddr;
  logic sOe;
  logic holdActive;

  edo_ctrl #(.AW(AW), .REF_BITS(REF_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .holdActive(holdActive), .ctl(ctl), .sAddr(sAddr), .sOe(sOe),
    .refPulse(refPulse), .refKind(refKind), .refRow(refRow)
  );

  edo_datapath #(.AW(AW), .DW(DW), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sAddr(sAddr), .sOe(sOe), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .holdActive(holdActive)
  );
endmodule

// File: rtl/edo_dram_emu_chk.sv
module edo_dram_emu_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          rasN,
  input logic          casN,
  input logic          oeN,
  input logic          dqOe,
  input logic [DW-1:0] dqOut,
  input logic          refPulse,
  input logic [1:0]    refKind,
  input logic          rdEn,
  input logic          wrEn,
  input logic          rowAct,
  input logic          refInt
);
  p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !$past(oeN));

  p_early_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn) |-> !dqOe);

  p_both_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rasN, 2) && $past(casN, 2)) |-> !dqOe);

  p_edo_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(dqOut));

  p_one_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdEn, wrEn, rowAct, refInt}));

  p_pulse_kind_r11: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |-> refKind != 2'd0);

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> !refPulse);
endmodule

bind edo_dram_emu edo_dram_emu_chk #(.DW(DW)) i_chk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .oeN(oeN),
  .dqOe(dqOe), .dqOut(dqOut), .refPulse(refPulse), .refKind(refKind),
  .rdEn(ctl.rdEn), .wrEn(ctl.wrEn), .rowAct(ctl.rowAct), .refInt(ctl.refInt)
);

// File: tb/test_edo_dram_emu.sv
module test_edo_dram_emu;
  localparam int AW = 11, DW = 4, RB = 3, CB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dqIn = '0;
  logic [DW-1:0] dqOut;
  logic dqOe, refPulse;
  logic [1:0] refKind;
  logic [AW-1:0] refRow;

  int vectors = 0, fails = 0;
  int pulses = 0, expPulses = 0;
  logic [DW-1:0] model [1 << (RB + CB)];
  logic [10:0] cntM = '0;
  logic [RB-1:0] curRow = '0;
  logic [DW-1:0] lastRd = '0;
  int unsigned seed;

  always #10 clk = ~clk;

  edo_dram_emu i_edo_dram_emu (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .refPulse(refPulse), .refKind(refKind), .refRow(refRow)
  );

  always @(posedge clk) if (rstN && refPulse) pulses++;

  function automatic int idxOf(input logic [RB-1:0] r, input logic [AW-1:0] c);
    return int'({r, c[CB-1:0]});
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w, input logic o,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    if (rasN && !r) expPulses++;
    rasN = r; casN = c; weN = w; oeN = o; addr = a; dqIn = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic openRow(input logic [AW-1:0] a);
    step(1, 1, 1, 0, a, 0);
    step(0, 1, 1, 0, a, 0);
    curRow = a[RB-1:0];
    check("R8 kind", 32'(refKind), 32'd2);
    check("R8 row", 32'(refRow), 32'(a));
  endtask

  task automatic wr(input logic [AW-1:0] c, input logic [DW-1:0] d);
    step(0, 0, 0, 0, c, d);
    model[idxOf(curRow, c)] = d;
    check("R5 early write hiz", 32'(dqOe), 0);
    step(0, 1, 1, 0, c, d);
  endtask

  task automatic rd(input logic [AW-1:0] c, input string req);
    step(0, 0, 1, 0, c, 0);
    lastRd = model[idxOf(curRow, c)];
    check(req, 32'(dqOe), 1);
    check(req, 32'(dqOut), 32'(lastRd));
  endtask

  task automatic cbr();
    step(1, 1, 1, 1, 0, 0);
    step(1, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    check("R7 kind", 32'(refKind), 32'd1);
    check("R7 row", 32'(refRow), 32'(cntM));
    cntM = cntM + 1'b1;
    step(1, 0, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dqOe", 32'(dqOe), 0);
    check("R1 refKind", 32'(refKind), 0);

    // R2 fill array page by page
    for (int r = 0; r < (1 << RB); r++) begin
      openRow(AW'(r));
      for (int c = 0; c < (1 << CB); c++) wr(AW'(c), DW'($urandom));
      step(1, 1, 1, 0, 0, 0);
    end

    // R3/R4/R5 directed read behaviour
    openRow(AW'(5));
    rd(AW'(2), "R3 read");
    step(0, 1, 1, 0, 2, 0);
    check("R4 hold dqOe", 32'(dqOe), 1);
    check("R4 hold data", 32'(dqOut), 32'(lastRd));
    step(0, 1, 1, 1, 2, 0);
    check("R5 oe high", 32'(dqOe), 0);
    step(0, 1, 1, 0, 2, 0);
    check("R4 oe back", 32'(dqOut), 32'(lastRd));
    rd(AW'(6), "R4 next fall");
    step(1, 1, 1, 0, 0, 0);
    check("R5 both high", 32'(dqOe), 0);

    // R6 random mixed page traffic
    for (int p = 0; p < 30; p++) begin
      openRow(AW'($urandom_range(0, (1 << RB) - 1)));
      for (int k = 0; k < 6; k++) begin
        logic [AW-1:0] c;
        c = AW'($urandom_range(0, (1 << CB) - 1));
        if ($urandom_range(0, 1) == 1) wr(c, DW'($urandom));
        else begin
          rd(c, "R6 page read");
          step(0, 1, 1, 0, c, 0);
        end
      end
      step(1, 1, 1, 0, 0, 0);
    end

    // R10 aliasing through high address bits
    openRow(AW'(11'h403));
    wr(AW'(11'h7F1), 4'hA);
    rd(AW'(11'h001), "R10 alias");
    step(1, 1, 1, 0, 0, 0);
    openRow(AW'(3));
    rd(AW'(1), "R10 alias row");
    check("R10 alias data", 32'(dqOut), 32'hA);
    step(1, 1, 1, 0, 0, 0);

    // R7 counter refresh leaves array unchanged
    cbr();
    cbr();
    openRow(AW'(3));
    rd(AW'(1), "R7 array kept");
    step(1, 1, 1, 0, 0, 0);

    // R9 hidden refresh
    openRow(AW'(4));
    rd(AW'(7), "R9 read");
    step(1, 0, 1, 0, 0, 0);
    check("R9 held ras high", 32'(dqOut), 32'(lastRd));
    step(0, 0, 1, 0, 0, 0);
    check("R9 kind", 32'(refKind), 32'd3);
    check("R9 row", 32'(refRow), 32'(cntM));
    check("R9 dqOe", 32'(dqOe), 1);
    check("R9 data", 32'(dqOut), 32'(lastRd));
    cntM = cntM + 1'b1;
    step(1, 0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0);
    check("R5 release", 32'(dqOe), 0);

    // R7 wrap of the counter
    while (cntM != 11'd0) cbr();
    cbr();

    step(1, 1, 1, 1, 0, 0);
    check("R11 pulses", 32'(pulses), 32'(expPulses));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule